// File: doc/BRIEF.md
# Call-Progress Tone Frequency Classifier

This block names the frequency of a call-progress tone, such as a dial, busy or ringback tone, from a one-bit squared copy of the line audio. The block counts system-clock cycles between rising edges of that input. It compares each measured period against thirteen fixed period windows derived from the clock rate. It reports a 4-bit band code once enough consecutive periods agree.

When the input falls silent, or stops settling into any window, the block reports a no-tone code. A one-cycle strobe marks each change of the reported code, so a host or a following state machine can react only to transitions. The clock rate, the agreement count, the failure window, the silence timeout and an optional register stage after the band lookup are all parameters. The default clock rate is 3579545 Hz.

The band windows and their codes are listed below. Each window has a lower edge and an upper edge in Hz, and the nominal tone is given in brackets.

| Code | Lower edge | Upper edge | Nominal |
|------|-----------|-----------|---------|
| 0x0 | 364 | 386 | 375 |
| 0x1 | 488 | 520 | 500 |
| 0x2 | 520 | 580 | 550 |
| 0x3 | 580 | 618 | 600 |
| 0x4 | 386 | 412 | 400 |
| 0x5 | 412 | 436 | 425 |
| 0x6 | 436 | 463 | 450 |
| 0x7 | 463 | 487 | 475 |
| 0x8 | 900 | 1008 | 950 |
| 0x9 | 1273 | 1325 | 1300 |
| 0xA | 1350 | 1455 | 1400 |
| 0xB | 1750 | 1855 | 1800 |
| 0xC | 2062 | 2140 | 2100 |

Top module: `cpt_tone_classifier`

## Requirements
- R1: While reset is applied, and after it until the first code change, code_o is 0xE and new_code_o is 0.
- R2: A measured period P is the number of clock cycles between two consecutive rising edges of tone_i. Band k matches P when round(CLK_HZ/upper_k) <= P <= round(CLK_HZ/lower_k), where round(a/b) = floor((2a+b)/(2b)), using the edges and codes 0x0 to 0xC of the band table.
- R3: When a period matches two bands (a shared edge), the band with the lower code is taken.
- R4: The first rising edge after reset or after a timeout only starts measurement. A band code is reported on the QUAL_COUNT-th consecutive measured period that matches that band, and not earlier.
- R5: A period that matches no band clears the run of agreeing periods. A period in a different band restarts the run at one.
- R6: When FAIL_LIMIT measured periods have passed since reset, since the last timeout, or since the last qualifying period, and none of them qualified, code 0xF (no tone) is reported.
- R7: Suppose TIMEOUT_CYC cycles pass after a rising edge with no further rising edge. Then code_o is 0xF from at most TIMEOUT_CYC+2+LOOKUP_PIPE cycles after that edge.
- R8: new_code_o is high for exactly one cycle, the first cycle in which code_o holds a new value, and is low whenever code_o is unchanged.
- R9: code_o never takes the value 0xD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock at CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tone_i | input | 1 | Squared audio, synchronous to clk_i |
| code_o | output | 4 | Band code 0x0 to 0xC, 0xE after reset, 0xF for no tone |
| new_code_o | output | 1 | One-cycle strobe on each change of code_o |

## Verification
The bench uses a scaled clock rate so that the periods are short. It sweeps every period from just below the highest band to just above the lowest band, with steady square waves. This separates in-band periods, out-of-band periods and every shared edge where two windows meet. Short bursts one period short of the agreement count show whether a code is reported too early. A single stray period inside a run shows whether the run restarts. A long out-of-band stream checks the failure window. Silence after a qualified tone brackets the timeout from both sides, and a switch between two bands checks that exactly one strobe marks each transition and none appears while a tone persists.

// File: rtl/cpt_pkg.sv
package cpt_pkg;

   localparam int unsigned NUM_BANDS   = 13;
   localparam int unsigned CODE_W      = 4;
   localparam logic [3:0]  CODE_RESET  = 4'hE;
   localparam logic [3:0]  CODE_NOTONE = 4'hF;

   // lower edge in Hz of each band, indexed by the reported code
   function automatic int unsigned band_floor_hz(input int unsigned idx);
      case (idx)
         0:  return 364;
         1:  return 488;
         2:  return 520;
         3:  return 580;
         4:  return 386;
         5:  return 412;
         6:  return 436;
         7:  return 463;
         8:  return 900;
         9:  return 1273;
         10: return 1350;
         11: return 1750;
         12: return 2062;
         default: return 1;
      endcase
   endfunction

   // upper edge in Hz of each band, indexed by the reported code
   function automatic int unsigned band_ceil_hz(input int unsigned idx);
      case (idx)
         0:  return 386;
         1:  return 520;
         2:  return 580;
         3:  return 618;
         4:  return 412;
         5:  return 436;
         6:  return 463;
         7:  return 487;
         8:  return 1008;
         9:  return 1325;
         10: return 1455;
         11: return 1855;
         12: return 2140;
         default: return 1;
      endcase
   endfunction

   // rounded clock cycles in one period of a tone at hz
   function automatic int unsigned hz_to_cycles(input int unsigned clk_hz, input int unsigned hz);
      return (2 * clk_hz + hz) / (2 * hz);
   endfunction

   // longest period, in cycles, that any band accepts
   function automatic int unsigned longest_period(input int unsigned clk_hz);
      int unsigned worst;
      worst = 0;
      for (int unsigned b = 0; b < NUM_BANDS; b++) begin
         if (hz_to_cycles(clk_hz, band_floor_hz(b)) > worst)
            worst = hz_to_cycles(clk_hz, band_floor_hz(b));
      end
      return worst;
   endfunction

endpackage

// File: rtl/cpt_period_meter.sv
module cpt_period_meter #(
   parameter int unsigned CNT_W       = 14,
   parameter int unsigned TIMEOUT_CYC = 12000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tone_i,
   output logic             meas_valid_o,
   output logic [CNT_W-1:0] meas_cycles_o,
   output logic             timeout_o
);

   localparam logic [CNT_W-1:0] CNT_MAX   = '1;
   localparam logic [CNT_W-1:0] TIMEOUT_C = CNT_W'(TIMEOUT_CYC);

   logic             tone_q;
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rise;

   assign rise          = tone_i & ~tone_q;
   assign meas_valid_o  = rise & armed_q;
   assign meas_cycles_o = cnt_q;
   assign timeout_o     = armed_q & ~rise & (cnt_q == TIMEOUT_C);

   // cnt_q holds the cycles elapsed since the last rising edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tone_q  <= 1'b0;
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         tone_q <= tone_i;
         if (rise) begin
            cnt_q   <= CNT_W'(1);
            armed_q <= 1'b1;
         end else begin
            if (cnt_q != CNT_MAX)
               cnt_q <= cnt_q + 1'b1;
            if (timeout_o)
               armed_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cpt_band_lookup.sv
module cpt_band_lookup
   import cpt_pkg::*;
#(
   parameter int unsigned CLK_HZ = 3579545,
   parameter int unsigned CNT_W  = 14
) (
   input  logic [CNT_W-1:0]  cycles_i,
   output logic              hit_o,
   output logic [CODE_W-1:0] band_o
);

   logic [NUM_BANDS-1:0] match;

   for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
      localparam int unsigned    SHORTEST = hz_to_cycles(CLK_HZ, band_ceil_hz(g));
      localparam int unsigned    LONGEST  = hz_to_cycles(CLK_HZ, band_floor_hz(g));
      localparam logic [CNT_W-1:0] LO_C   = CNT_W'(SHORTEST);
      localparam logic [CNT_W-1:0] HI_C   = CNT_W'(LONGEST);
      if (SHORTEST == 0 || SHORTEST > LONGEST) begin : g_bad_window
         $error("cpt_band_lookup: band window collapses at this clock rate");
      end
      assign match[g] = (cycles_i >= LO_C) && (cycles_i <= HI_C);
   end

   // lowest code wins on a shared edge (R3)
   always_comb begin
      band_o = '0;
      for (int i = int'(NUM_BANDS) - 1; i >= 0; i--) begin
         if (match[i])
            band_o = CODE_W'(i);
      end
   end

   assign hit_o = |match;

endmodule

// File: rtl/cpt_qualifier.sv
module cpt_qualifier
   import cpt_pkg::*;
#(
   parameter int unsigned QUAL_COUNT = 8,
   parameter int unsigned FAIL_LIMIT = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              meas_valid_i,
   input  logic              hit_i,
   input  logic [CODE_W-1:0] band_i,
   input  logic              timeout_i,
   output logic [CODE_W-1:0] code_o,
   output logic              new_code_o
);

   localparam int unsigned RUN_W  = $clog2(QUAL_COUNT + 1);
   localparam int unsigned FAIL_W = $clog2(FAIL_LIMIT + 1);
   localparam logic [RUN_W-1:0]  RUN_FULL  = RUN_W'(QUAL_COUNT);
   localparam logic [FAIL_W-1:0] FAIL_LAST = FAIL_W'(FAIL_LIMIT);

   logic [CODE_W-1:0] run_band_q, run_band_n;
   logic [RUN_W-1:0]  run_len_q,  run_len_n, len_step;
   logic [FAIL_W-1:0] fail_q,     fail_n,    fail_step;
   logic [CODE_W-1:0] code_q,     code_n;
   logic              strobe_q;
   logic              same_band, qualified;

   always_comb begin
      same_band = (run_len_q != '0) && (run_band_q == band_i);
      if (!hit_i)
         len_step = '0;                    // R5: stray period clears the run
      else if (!same_band)
         len_step = RUN_W'(1);             // R5: new band restarts at one
      else if (run_len_q == RUN_FULL)
         len_step = RUN_FULL;
      else
         len_step = run_len_q + 1'b1;
      qualified = hit_i && (len_step == RUN_FULL);
      fail_step = (fail_q == FAIL_LAST) ? fail_q : fail_q + 1'b1;

      run_band_n = run_band_q;
      run_len_n  = run_len_q;
      fail_n     = fail_q;
      code_n     = code_q;
      if (timeout_i) begin
         run_len_n = '0;
         fail_n    = '0;
         code_n    = CODE_NOTONE;          // R7
      end else if (meas_valid_i) begin
         run_band_n = band_i;
         run_len_n  = len_step;
         if (qualified) begin
            fail_n = '0;
            code_n = band_i;               // R4
         end else begin
            fail_n = fail_step;
            if (fail_step == FAIL_LAST)
               code_n = CODE_NOTONE;       // R6
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_band_q <= '0;
         run_len_q  <= '0;
         fail_q     <= '0;
         code_q     <= CODE_RESET;         // R1
         strobe_q   <= 1'b0;
      end else begin
         run_band_q <= run_band_n;
         run_len_q  <= run_len_n;
         fail_q     <= fail_n;
         code_q     <= code_n;
         strobe_q   <= (code_n != code_q); // R8
      end
   end

   assign code_o     = code_q;
   assign new_code_o = strobe_q;

endmodule

// File: rtl/cpt_tone_classifier.sv
module cpt_tone_classifier
   import cpt_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 3579545,
   parameter int unsigned QUAL_COUNT  = 8,
   parameter int unsigned FAIL_LIMIT  = 16,
   parameter int unsigned TIMEOUT_CYC = 12000,
   parameter int unsigned LOOKUP_PIPE = 0
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       tone_i,
   output logic [3:0] code_o,
   output logic       new_code_o
);

   localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 2);

   if (QUAL_COUNT < 1) begin : g_bad_qual
      $error("cpt_tone_classifier: QUAL_COUNT must be at least 1");
   end
   if (FAIL_LIMIT <= QUAL_COUNT) begin : g_bad_fail
      $error("cpt_tone_classifier: FAIL_LIMIT must exceed QUAL_COUNT");
   end
   if (TIMEOUT_CYC <= longest_period(CLK_HZ)) begin : g_bad_timeout
      $error("cpt_tone_classifier: TIMEOUT_CYC must exceed the longest band period");
   end
   if (LOOKUP_PIPE > 1) begin : g_bad_pipe
      $error("cpt_tone_classifier: LOOKUP_PIPE must be 0 or 1");
   end

   logic              meas_valid, meas_timeout;
   logic [CNT_W-1:0]  meas_cycles;
   logic              look_hit;
   logic [CODE_W-1:0] look_band;
   logic              q_valid, q_hit, q_timeout;
   logic [CODE_W-1:0] q_band;

   cpt_period_meter #(
      .CNT_W       (CNT_W),
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) i_meter (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .tone_i        (tone_i),
      .meas_valid_o  (meas_valid),
      .meas_cycles_o (meas_cycles),
      .timeout_o     (meas_timeout)
   );

   cpt_band_lookup #(
      .CLK_HZ (CLK_HZ),
      .CNT_W  (CNT_W)
   ) i_lookup (
      .cycles_i (meas_cycles),
      .hit_o    (look_hit),
      .band_o   (look_band)
   );

   if (LOOKUP_PIPE != 0) begin : g_pipe
      logic              valid_q, hit_q, timeout_q;
      logic [CODE_W-1:0] band_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            valid_q   <= 1'b0;
            hit_q     <= 1'b0;
            timeout_q <= 1'b0;
            band_q    <= '0;
         end else begin
            valid_q   <= meas_valid;
            hit_q     <= look_hit;
            timeout_q <= meas_timeout;
            band_q    <= look_band;
         end
      end
      assign q_valid   = valid_q;
      assign q_hit     = hit_q;
      assign q_timeout = timeout_q;
      assign q_band    = band_q;
   end else begin : g_direct
      assign q_valid   = meas_valid;
      assign q_hit     = look_hit;
      assign q_timeout = meas_timeout;
      assign q_band    = look_band;
   end

   cpt_qualifier #(
      .QUAL_COUNT (QUAL_COUNT),
      .FAIL_LIMIT (FAIL_LIMIT)
   ) i_qualifier (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .meas_valid_i (q_valid),
      .hit_i        (q_hit),
      .band_i       (q_band),
      .timeout_i    (q_timeout),
      .code_o       (code_o),
      .new_code_o   (new_code_o)
   );

endmodule

// File: rtl/cpt_tone_classifier_chk.sv
module cpt_tone_classifier_chk #(
   parameter int unsigned TIMEOUT_CYC = 12000,
   parameter int unsigned LOOKUP_PIPE = 0
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       tone_i,
   input logic [3:0] code_o,
   input logic       new_code_o
);

   localparam int unsigned SETTLE = TIMEOUT_CYC + 2 + LOOKUP_PIPE;

   logic        tone_q, seen_q;
   int unsigned idle_q;

   // independent count of cycles since the last rising edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tone_q <= 1'b0;
         seen_q <= 1'b0;
         idle_q <= 0;
      end else begin
         tone_q <= tone_i;
         if (tone_i && !tone_q) begin
            idle_q <= 1;
            seen_q <= 1'b1;
         end else if (idle_q <= SETTLE) begin
            idle_q <= idle_q + 1;
         end
      end
   end

   AST_STROBE_MEANS_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      new_code_o |-> (code_o != $past(code_o)));   // R8
   AST_CHANGE_MEANS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_o != $past(code_o)) |-> new_code_o);   // R8
   AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      new_code_o |=> !new_code_o);                 // R8
   AST_NO_RESERVED_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_o != 4'hD);                             // R9
   AST_SILENCE_NOTONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen_q && idle_q >= SETTLE) |-> (code_o == 4'hF)); // R7

endmodule

bind cpt_tone_classifier cpt_tone_classifier_chk #(
   .TIMEOUT_CYC (TIMEOUT_CYC),
   .LOOKUP_PIPE (LOOKUP_PIPE)
) i_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .tone_i     (tone_i),
   .code_o     (code_o),
   .new_code_o (new_code_o)
);

// File: tb/test_cpt_tone_classifier.sv
module test_cpt_tone_classifier;

   localparam int T_CLK_HZ  = 35795;
   localparam int T_QUAL    = 4;
   localparam int T_FAIL    = 6;
   localparam int T_TIMEOUT = 120;
   localparam int T_PIPE    = 1;

   localparam int LOW_HZ  [13] = '{364, 488, 520, 580, 386, 412, 436, 463, 900, 1273, 1350, 1750, 2062};
   localparam int HIGH_HZ [13] = '{386, 520, 580, 618, 412, 436, 463, 487, 1008, 1325, 1455, 1855, 2140};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tone = 1'b0;
   logic [3:0] code;
   logic       strobe;

   int n_checks = 0;
   int n_err = 0;
   int strobe_cnt = 0;
   int bad_code_cnt = 0;

   always #4 clk = ~clk;

   cpt_tone_classifier #(
      .CLK_HZ      (T_CLK_HZ),
      .QUAL_COUNT  (T_QUAL),
      .FAIL_LIMIT  (T_FAIL),
      .TIMEOUT_CYC (T_TIMEOUT),
      .LOOKUP_PIPE (T_PIPE)
   ) i_cpt_tone_classifier (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .tone_i     (tone),
      .code_o     (code),
      .new_code_o (strobe)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (strobe) strobe_cnt++;
         if (code == 4'hD) bad_code_cnt++;
      end
   end

   function automatic int cyc_round(input int hz);
      return (2 * T_CLK_HZ + hz) / (2 * hz);
   endfunction

   function automatic int first_band(input int p);
      for (int k = 0; k < 13; k++)
         if (p >= cyc_round(HIGH_HZ[k]) && p <= cyc_round(LOW_HZ[k])) return k;
      return -1;
   endfunction

   function automatic int band_hits(input int p);
      int n;
      n = 0;
      for (int k = 0; k < 13; k++)
         if (p >= cyc_round(HIGH_HZ[k]) && p <= cyc_round(LOW_HZ[k])) n++;
      return n;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tone  = 1'b0;
      repeat (3) @(negedge clk);
      strobe_cnt = 0;
      rst_n = 1'b1;
   endtask

   // one rising edge followed by p cycles until the next one
   task automatic pulse(input int p);
      tone = 1'b1;
      repeat (p / 2) @(negedge clk);
      tone = 1'b0;
      repeat (p - p / 2) @(negedge clk);
   endtask

   localparam int P_A   = 38;  // band 0x8 only
   localparam int P_B   = 65;  // band 0x2 only
   localparam int P_OUT = 50;  // between bands

   initial begin
      int exp_code;
      int hits;

      // R1: reset state
      do_reset();
      repeat (2) @(negedge clk);
      check(code == 4'hE, "R1 code", code, 4'hE);
      check(strobe == 1'b0, "R1 strobe", strobe, 0);

      // R2/R3/R6/R8: sweep steady square waves across the whole range
      for (int p = 16; p <= 100; p++) begin
         do_reset();
         repeat (8) pulse(p);
         exp_code = (first_band(p) < 0) ? 15 : first_band(p);
         hits = band_hits(p);
         if (hits > 1)
            check(code == exp_code[3:0], "R3 shared edge", code, exp_code);
         else if (hits == 1)
            check(code == exp_code[3:0], "R2 band map", code, exp_code);
         else
            check(code == exp_code[3:0], "R6 out of band", code, exp_code);
         check(strobe_cnt == 1, "R8 one strobe", strobe_cnt, 1);
      end

      // R4: not reported before the agreement count
      do_reset();
      repeat (4) pulse(P_A);
      check(code == 4'hE, "R4 early", code, 4'hE);
      check(strobe_cnt == 0, "R4 early strobe", strobe_cnt, 0);
      pulse(P_A);
      check(code == 4'h8, "R4 qualified", code, 4'h8);

      // R6: failure window boundary
      do_reset();
      repeat (6) pulse(P_OUT);
      check(code == 4'hE, "R6 before window", code, 4'hE);
      pulse(P_OUT);
      check(code == 4'hF, "R6 at window", code, 4'hF);

      // R5: stray period restarts qualification
      do_reset();
      repeat (3) pulse(P_A);
      pulse(P_OUT);
      repeat (4) pulse(P_A);
      check(code == 4'hF, "R5 restart", code, 4'hF);
      pulse(P_A);
      check(code == 4'h8, "R5 requalify", code, 4'h8);
      check(strobe_cnt == 2, "R8 two changes", strobe_cnt, 2);

      // R7: silence after a tone, bracketed on both sides
      repeat (60) @(negedge clk);
      check(code == 4'h8, "R7 before timeout", code, 4'h8);
      repeat (40) @(negedge clk);
      check(code == 4'hF, "R7 after timeout", code, 4'hF);
      check(strobe_cnt == 3, "R8 timeout strobe", strobe_cnt, 3);

      // R8: steady tone gives one strobe, band switch gives one more
      do_reset();
      repeat (12) pulse(P_A);
      check(code == 4'h8, "R8 steady code", code, 4'h8);
      check(strobe_cnt == 1, "R8 steady strobe", strobe_cnt, 1);
      repeat (4) pulse(P_B);
      check(code == 4'h8, "R4 switch early", code, 4'h8);
      pulse(P_B);
      check(code == 4'h2, "R8 switched code", code, 4'h2);
      check(strobe_cnt == 2, "R8 switch strobe", strobe_cnt, 2);

      // R9: reserved code never seen
      check(bad_code_cnt == 0, "R9 reserved code", bad_code_cnt, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
   end

endmodule